// File: doc/BRIEF.md
# Qualified Event Counter

This block is one performance-monitoring counter slice. Every clock cycle it receives the number of times an event happened in that cycle on this hardware thread, the same number from the sibling thread, and the privilege level the thread is running at. A small control register decides how those inputs turn into counter increments. The threads can be summed, a threshold compare can turn the sum into a per-cycle condition, the condition can be inverted and reduced to its rising edges, and the result is gated by user and kernel privilege filters and a global enable.

A single write port either loads the control register or presets the wide counter. A sticky flag records that the counter carried out of its top bit. A typical use is to preset the counter to a value just below the wrap point, so the flag marks when a chosen number of qualified events has been seen.

Top module: `qual_evt_counter`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0 and the control register is 0, so no counting takes place until it is written.
- R2: Control bit 0 (user enable) permits counting while the privilege level input is 1, 2 or 3. Control bit 1 (kernel enable) permits counting while it is 0. At any level whose enable bit is clear the count holds.
- R3: With the threshold field (control bits 15:8) at 0 and the invert and edge bits clear, each counted cycle adds the raw event sum to the count.
- R4: With a nonzero threshold, a counted cycle adds exactly 1 when the event sum is greater than or equal to the threshold, and adds 0 otherwise.
- R5: Control bit 2 (invert) makes the block add 1 in cycles where the condition is false. With a zero threshold the condition is "sum nonzero".
- R6: Control bit 3 (edge) makes the block add 1 only when the (possibly inverted) condition goes from false to true. The stored previous condition is reset to false by every control write.
- R7: Control bit 4 (any-thread) adds the sibling thread's count into the event sum. When the bit is clear, the sibling input has no effect.
- R8: While the global enable input is low, the count holds.
- R9: A write with select 0 loads control bits 15:0 from the write data, and a write with select 1 loads the count. Either write is visible the next cycle, and no event is counted in the write cycle.
- R10: When an addition carries out of the top counter bit, the overflow flag sets and stays set until any register write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global count enable |
| priv_lvl | input | 2 | Current privilege level, 0 is kernel |
| evt_cnt | input | EVT_W (4) | Event occurrences this cycle, own thread |
| peer_cnt | input | EVT_W (4) | Event occurrences this cycle, sibling thread |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 count |
| wr_data | input | CNT_W (48) | Write data |
| count | output | CNT_W (48) | Current count |
| ovf | output | 1 | Sticky overflow flag |

## Verification
On every cycle, the embedded assertions check that the count holds while the privilege filter, global enable or a write blocks it, and that a nonzero threshold never adds more than one per cycle. They also check that a count write lands exactly, that the overflow flag stays set until a write, and that edge mode cannot fire twice without an intervening falling condition. The exact increment for each combination of filter, threshold, inversion and thread summing can only be shown by the bench's vectors. The same holds for the rising-edge sequence, the edge-state clear on a control rewrite, and the wrap from a preset value.

// File: rtl/qec_pkg.sv
package qec_pkg;

   localparam int THR_W  = 8;
   localparam int CTRL_W = 16;

   typedef struct packed {
      logic [THR_W-1:0] thr;
      logic [2:0]       rsvd;
      logic             any_thr;
      logic             edge_det;
      logic             invert;
      logic             kern_en;
      logic             user_en;
   } qec_ctrl_t;

   typedef enum logic {
      SEL_CTRL  = 1'b0,
      SEL_COUNT = 1'b1
   } qec_sel_e;

   function automatic logic priv_permits(qec_ctrl_t c, logic [1:0] lvl);
      return (lvl == 2'd0) ? c.kern_en : c.user_en;
   endfunction

endpackage

// File: rtl/qec_qualify.sv
module qec_qualify
   import qec_pkg::*;
#(
   parameter int EVT_W         = 4,
   parameter bit ANY_THREAD_EN = 1'b1,
   localparam int SUM_W        = EVT_W + 1
) (
   input  qec_ctrl_t        ctrl,
   input  logic [EVT_W-1:0] evt_cnt,
   input  logic [EVT_W-1:0] peer_cnt,
   output logic [SUM_W-1:0] sum,
   output logic             cond,
   output logic             raw_mode
);

   localparam int CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W;

   logic [CMP_W-1:0] sum_x;
   logic [CMP_W-1:0] thr_x;
   logic             base;

   generate
      if (ANY_THREAD_EN) begin : g_pair
         always_comb begin
            if (ctrl.any_thr) sum = {1'b0, evt_cnt} + {1'b0, peer_cnt};
            else              sum = {1'b0, evt_cnt};
         end
      end else begin : g_solo
         assign sum = {1'b0, evt_cnt};
      end
   endgenerate

   assign sum_x = CMP_W'(sum);
   assign thr_x = CMP_W'(ctrl.thr);

   always_comb begin
      if (ctrl.thr == '0) base = (sum != '0);
      else                base = (sum_x >= thr_x);
   end

   assign cond     = base ^ ctrl.invert;
   assign raw_mode = (ctrl.thr == '0) && !ctrl.invert && !ctrl.edge_det;

endmodule

// File: rtl/qec_edge.sv
module qec_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic edge_mode,
   input  logic cond_in,
   output logic fire
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev_q <= 1'b0;
      else if (clr) prev_q <= 1'b0;
      else          prev_q <= cond_in;
   end

   assign fire = edge_mode ? (cond_in && !prev_q) : cond_in;

   // R6
   edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && fire && !clr) |=> !(edge_mode && fire));

endmodule

// File: rtl/qec_accum.sv
module qec_accum #(
   parameter int CNT_W = 48,
   parameter int INC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] inc,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clr_ovf,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);

   logic [CNT_W:0] nxt;

   assign nxt = {1'b0, count} + (CNT_W+1)'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (load) count <= load_val;
         else      count <= nxt[CNT_W-1:0];
         if (clr_ovf) ovf <= 1'b0;
         else         ovf <= ovf | nxt[CNT_W];
      end
   end

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_ovf) |=> ovf);

   // R10
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ovf |=> !ovf);

   // R9
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_val)));

endmodule

// File: rtl/qual_evt_counter.sv
module qual_evt_counter
   import qec_pkg::*;
#(
   parameter int EVT_W         = 4,
   parameter int CNT_W         = 48,
   parameter bit ANY_THREAD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glb_en,
   input  logic [1:0]       priv_lvl,
   input  logic [EVT_W-1:0] evt_cnt,
   input  logic [EVT_W-1:0] peer_cnt,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);

   localparam int SUM_W = EVT_W + 1;

   generate
      if (EVT_W < 1) begin : g_bad_evt
         $error("EVT_W must be at least 1");
      end
      if (CNT_W < CTRL_W || CNT_W < SUM_W + 1) begin : g_bad_cnt
         $error("CNT_W too small for control word or increment");
      end
   endgenerate

   qec_ctrl_t        ctrl_q;
   logic             ctrl_wr;
   logic             cnt_wr;
   logic [SUM_W-1:0] sum;
   logic             cond;
   logic             raw_mode;
   logic             fire;
   logic             gate;
   logic [SUM_W-1:0] inc;

   assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
   assign cnt_wr  = wr_en && (wr_sel == SEL_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= qec_ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   qec_qualify #(
      .EVT_W        (EVT_W),
      .ANY_THREAD_EN(ANY_THREAD_EN)
   ) i_qualify (
      .ctrl    (ctrl_q),
      .evt_cnt (evt_cnt),
      .peer_cnt(peer_cnt),
      .sum     (sum),
      .cond    (cond),
      .raw_mode(raw_mode)
   );

   qec_edge i_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ctrl_wr),
      .edge_mode(ctrl_q.edge_det),
      .cond_in  (cond),
      .fire     (fire)
   );

   assign gate = glb_en && !wr_en && priv_permits(ctrl_q, priv_lvl);

   always_comb begin
      if (!gate)         inc = '0;
      else if (raw_mode) inc = sum;
      else               inc = SUM_W'(fire);
   end

   qec_accum #(
      .CNT_W(CNT_W),
      .INC_W(SUM_W)
   ) i_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc),
      .load    (cnt_wr),
      .load_val(wr_data),
      .clr_ovf (wr_en),
      .count   (count),
      .ovf     (ovf)
   );

   // R2
   priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !priv_permits(ctrl_q, priv_lvl)) |=> $stable(count));

   // R8
   glb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !glb_en) |=> $stable(count));

   // R9
   ctrl_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> $stable(count));

   // R4
   thr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && ctrl_q.thr != '0) |=> ((count - $past(count)) <= CNT_W'(1)));

endmodule

// File: tb/test_qual_evt_counter.sv
module test_qual_evt_counter;

   localparam int EVT_W = 4;
   localparam int CNT_W = 48;
   localparam int NV    = 14;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             glb_en = 1'b0;
   logic [1:0]       priv_lvl = '0;
   logic [EVT_W-1:0] evt_cnt = '0;
   logic [EVT_W-1:0] peer_cnt = '0;
   logic             wr_en = 1'b0;
   logic             wr_sel = 1'b0;
   logic [CNT_W-1:0] wr_data = '0;
   logic [CNT_W-1:0] count;
   logic             ovf;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   qual_evt_counter #(.EVT_W(EVT_W), .CNT_W(CNT_W)) i_qual_evt_counter (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .priv_lvl(priv_lvl),
      .evt_cnt(evt_cnt), .peer_cnt(peer_cnt), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .count(count), .ovf(ovf)
   );

   // ctrl[34:19] evt[18:15] peer[14:11] priv[10:9] glb[8] expected[7:0]
   localparam logic [34:0] VEC [NV] = '{
      {16'h0001, 4'd5, 4'd0, 2'd3, 1'b1, 8'd5},  // R3 R2 user raw
      {16'h0001, 4'd5, 4'd0, 2'd0, 1'b1, 8'd0},  // R2 user only, kernel level
      {16'h0002, 4'd7, 4'd0, 2'd0, 1'b1, 8'd7},  // R2 kernel
      {16'h0002, 4'd7, 4'd0, 2'd2, 1'b1, 8'd0},  // R2 kernel only, level 2
      {16'h0003, 4'd5, 4'd0, 2'd1, 1'b0, 8'd0},  // R8 global off
      {16'h0301, 4'd3, 4'd0, 2'd1, 1'b1, 8'd1},  // R4 equal threshold
      {16'h0301, 4'd2, 4'd0, 2'd1, 1'b1, 8'd0},  // R4 below threshold
      {16'h0005, 4'd0, 4'd0, 2'd1, 1'b1, 8'd1},  // R5 invert, no event
      {16'h0005, 4'd4, 4'd0, 2'd1, 1'b1, 8'd0},  // R5 invert, event
      {16'h0011, 4'd3, 4'd4, 2'd1, 1'b1, 8'd7},  // R7 thread sum
      {16'h0001, 4'd3, 4'd4, 2'd1, 1'b1, 8'd3},  // R7 sibling ignored
      {16'h0811, 4'd5, 4'd3, 2'd1, 1'b1, 8'd1},  // R7 R4 sum meets thr
      {16'h0807, 4'd9, 4'd0, 2'd1, 1'b1, 8'd0},  // R5 R4 inverted above
      {16'h0009, 4'd2, 4'd0, 2'd1, 1'b1, 8'd1}   // R6 first edge
   };

   task automatic chk(string req, logic [CNT_W-1:0] got, logic [CNT_W-1:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(logic sel, logic [CNT_W-1:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic step(logic [EVT_W-1:0] e);
      evt_cnt = e;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 count", count, '0);
      chk("R1 ovf", {47'd0, ovf}, '0);
      rst_n = 1'b1;
      glb_en = 1'b1; priv_lvl = 2'd3;
      step(4'd6);
      chk("R1 idle control", count, '0);
      evt_cnt = '0;

      for (int v = 0; v < NV; v++) begin
         glb_en = 1'b0; evt_cnt = '0; peer_cnt = '0;
         wr(1'b0, CNT_W'(VEC[v][34:19]));
         wr(1'b1, '0);
         evt_cnt  = VEC[v][18:15];
         peer_cnt = VEC[v][14:11];
         priv_lvl = VEC[v][10:9];
         glb_en   = VEC[v][8];
         @(negedge clk);
         evt_cnt = '0; peer_cnt = '0;
         chk($sformatf("vector %0d", v), count, CNT_W'(VEC[v][7:0]));
      end

      // R9: write cycle counts nothing
      priv_lvl = 2'd1; glb_en = 1'b1;
      wr(1'b1, CNT_W'(40));
      wr(1'b0, CNT_W'(16'h0001));
      evt_cnt = 4'd5; wr(1'b0, CNT_W'(16'h0001));
      chk("R9 ctrl write no count", count, CNT_W'(40));
      evt_cnt = 4'd5; wr(1'b1, CNT_W'(100));
      chk("R9 count write loads", count, CNT_W'(100));
      evt_cnt = '0;

      // R6: rising edges only, cleared by control write
      wr(1'b0, CNT_W'(16'h0009));
      wr(1'b1, '0);
      step(4'd1); step(4'd1); step(4'd1);
      chk("R6 held condition once", count, CNT_W'(1));
      step(4'd0); step(4'd1); step(4'd1);
      chk("R6 second edge", count, CNT_W'(2));
      evt_cnt = 4'd1; wr(1'b0, CNT_W'(16'h0009));
      step(4'd1);
      chk("R6 edge state cleared", count, CNT_W'(3));
      evt_cnt = '0;

      // R10: wrap sets sticky flag, write clears it
      wr(1'b0, CNT_W'(16'h0001));
      wr(1'b1, {{(CNT_W-1){1'b1}}, 1'b0});
      step(4'd3);
      chk("R10 wrap value", count, CNT_W'(1));
      chk("R10 flag set", {47'd0, ovf}, CNT_W'(1));
      step(4'd0); step(4'd2);
      chk("R10 flag sticky", {47'd0, ovf}, CNT_W'(1));
      chk("R10 count after wrap", count, CNT_W'(3));
      wr(1'b0, CNT_W'(16'h0001));
      chk("R10 flag cleared", {47'd0, ovf}, '0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule